// File: doc/BRIEF.md
# Transmitter Configuration Command Decoder

This block is the serial slave front end and configuration store of a radio transmitter. A host shifts commands in over a four-wire serial link: a select line that is active low, a serial clock and a data input. The block samples these lines with its own system clock, collects each command most significant bit first, and identifies the command from its leading opcode bits. Opcodes come in three lengths: 3, 4 and 8 bits. The block then writes the payload into the matching configuration register and presents that register as decoded fields to the analog and control logic around it.

Three commands are range-checked before they are written: the carrier frequency word, the wake-up exponent and one reserved wake-up code. The reserved code is a software reset that reloads every register. The sleep and transmit commands also produce one-cycle strobes. A status-read command turns the interrupt output into a serial data output for the rest of the transfer. Outside a status read, the interrupt output passes the external interrupt request through unchanged.

Top module: `txcfg_spi_decoder`

## Requirements
- R1: After reset the fields hold their defaults: config payload 0x080 (band 0, clock select 0, load cap 8, polarity 0, deviation 0), power enables 0x00, frequency 0x7D0, rate 0x00, PA OOK 0 and attenuation 0, battery config 0x00, clock tail 0x10, button config 0x00, wake exponent 0 and mantissa 0x00, PLL config 0x00, transmit length 0x00.
- R2: A data bit is taken on each rising edge of the serial clock while the select line is low, most significant bit first. Select high clears the bit count. A register changes only after its whole command has arrived, and a command cut short by select rising changes nothing.
- R3: Opcodes: 100b = config (payload bits 12:0; band 12:11, clock select 10:8, load cap 7:4, polarity 3, deviation 2:0); 1010b = frequency (bits 11:0); 111b = wake-up (exponent 12:8, mantissa 7:0). The 8-bit opcodes C0h, C8h, C2h, C4h, CAh and D2h write power enables, rate, battery config, clock tail, button config and PLL config from bits 7:0. These are 16-bit commands. The power setting is an 8-bit command 1011b followed by OOK in bit 3 and attenuation in bits 2:0.
- R4: A frequency value outside 96..3903 leaves the frequency field unchanged.
- R5: A wake-up command whose exponent is above 23 leaves the wake-up fields unchanged.
- R6: The word FE00h reloads every register with its R1 default and pulses the soft-reset strobe for one cycle. Other 111b words with exponent 30 are rejected under R5 and do not reset.
- R7: Command C4h,S writes S into the clock tail field and pulses the sleep strobe once.
- R8: Command C6h,N sets the transmit length to N and pulses the transmit strobe once.
- R9: A status read starts with first byte CCh. On the falling clock edge after the 8th bit, the status input is captured and its bit 15 is driven on the interrupt output. Each later falling edge presents the next lower bit. With no status read active, the interrupt output follows the interrupt input.
- R10: Only the first command in a select window takes effect; bits after it are ignored. Unknown opcodes, such as 1234h, D0FFh and CE55h, change nothing. A status read changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from host |
| sel_ni | input | 1 | Select, active low |
| sdi_i | input | 1 | Serial data from host |
| irq_ni | input | 1 | Interrupt request, active low |
| status_i | input | 16 | Status word for readout |
| irq_no | output | 1 | Interrupt output, or serial status data during a status read |
| band_o | output | 2 | Frequency band |
| clk_sel_o | output | 3 | Clock output divider select |
| xtal_cap_o | output | 4 | Crystal load capacitance code |
| dev_pol_o | output | 1 | Deviation polarity |
| dev_o | output | 3 | Deviation code |
| pm_en_o | output | 8 | Power management enables |
| freq_o | output | 12 | Carrier frequency word |
| rate_o | output | 8 | Bit rate divider |
| pa_ook_o | output | 1 | PA on-off keying enable |
| pa_att_o | output | 3 | PA attenuation step |
| lbd_cfg_o | output | 8 | Battery detector config (threshold in bits 4:0) |
| clk_tail_o | output | 8 | Clock tail length |
| pb_cfg_o | output | 8 | Push-button config |
| wk_exp_o | output | 5 | Wake-up exponent |
| wk_mant_o | output | 8 | Wake-up mantissa |
| pll_cfg_o | output | 8 | PLL config |
| tx_len_o | output | 8 | Transmit byte count |
| sleep_stb_o | output | 1 | Sleep command strobe |
| tx_stb_o | output | 1 | Transmit command strobe |
| swrst_stb_o | output | 1 | Software reset strobe |

## Verification
The hardest case to reach from the ports is the status readout. Its timing depends on telling apart the falling clock edge that arms the capture from the edges that shift, and on the serial data and the external interrupt sharing one pin. The bench samples the interrupt output just before every rising edge of a 24-bit transfer and compares the last sixteen samples with several status patterns. Truncated frames, trailing bits and the reserved reset word inside the wake-up opcode space are driven with exact bit counts.

// File: rtl/txcfg_pkg.sv
package txcfg_pkg;
  localparam int CMD_W = 16;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_CFG, CMD_PM, CMD_FREQ, CMD_RATE, CMD_PWR, CMD_LBD,
    CMD_SLEEP, CMD_PB, CMD_WAKE, CMD_PLL, CMD_TX, CMD_STAT
  } cmd_e;

  localparam logic [12:0] CFG_DEF   = 13'h0080;
  localparam logic [7:0]  PM_DEF    = 8'h00;
  localparam logic [11:0] FREQ_DEF  = 12'h7D0;
  localparam logic [7:0]  RATE_DEF  = 8'h00;
  localparam logic [3:0]  PWR_DEF   = 4'h0;
  localparam logic [7:0]  LBD_DEF   = 8'h00;
  localparam logic [7:0]  SLEEP_DEF = 8'h10;
  localparam logic [7:0]  PB_DEF    = 8'h00;
  localparam logic [12:0] WK_DEF    = 13'h0000;
  localparam logic [7:0]  PLL_DEF   = 8'h00;
  localparam logic [7:0]  TXL_DEF   = 8'h00;
  localparam logic [15:0] SWRST_CODE = 16'hFE00;

  function automatic cmd_e classify(input logic [7:0] op);
    cmd_e k;
    unique case (op)
      8'hC0:   k = CMD_PM;
      8'hC2:   k = CMD_LBD;
      8'hC4:   k = CMD_SLEEP;
      8'hC6:   k = CMD_TX;
      8'hC8:   k = CMD_RATE;
      8'hCA:   k = CMD_PB;
      8'hCC:   k = CMD_STAT;
      8'hD2:   k = CMD_PLL;
      default: begin
        if (op[7:5] == 3'b100)       k = CMD_CFG;
        else if (op[7:4] == 4'b1010) k = CMD_FREQ;
        else if (op[7:4] == 4'b1011) k = CMD_PWR;
        else if (op[7:5] == 3'b111)  k = CMD_WAKE;
        else                         k = CMD_NONE;
      end
    endcase
    return k;
  endfunction
endpackage

// File: rtl/txcfg_sync.sv
module txcfg_sync #(
  parameter int         STAGES  = 2,
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/txcfg_shift.sv
module txcfg_shift
  import txcfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_n_i,
  input  logic             sck_rise_i,
  input  logic             sdi_i,
  output logic             cmd_vld_o,
  output logic [CMD_W-1:0] cmd_word_o,
  output logic             stat_arm_o
);
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam int OP_W  = 8;

  logic [CMD_W-1:0] sr_q, sr_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             done_q;
  logic             take, at_op, short_op, full_len, commit;
  cmd_e             op_kind;

  assign take     = sck_rise_i && !sel_n_i && !done_q;
  assign sr_nx    = {sr_q[CMD_W-2:0], sdi_i};
  assign cnt_nx   = cnt_q + 1'b1;
  assign at_op    = (cnt_nx == CNT_W'(OP_W));
  assign op_kind  = classify(sr_nx[OP_W-1:0]);
  assign short_op = at_op && (op_kind == CMD_PWR);
  assign full_len = (cnt_nx == CNT_W'(CMD_W));
  assign commit   = take && (short_op || full_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (sel_n_i) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      sr_q   <= sr_nx;
      cnt_q  <= cnt_nx;
      done_q <= commit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_vld_o  <= 1'b0;
      cmd_word_o <= '0;
      stat_arm_o <= 1'b0;
    end else begin
      cmd_vld_o  <= commit;
      stat_arm_o <= take && at_op && (op_kind == CMD_STAT);
      if (commit)
        cmd_word_o <= short_op ? {sr_nx[OP_W-1:0], {(CMD_W-OP_W){1'b0}}} : sr_nx;
    end
  end

  // R2: a command is only accepted while the select window was open
  p_commit_in_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> !$past(sel_n_i));
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CMD_W));
endmodule

// File: rtl/txcfg_regs.sv
module txcfg_regs
  import txcfg_pkg::*;
#(
  parameter int FREQ_MIN   = 96,
  parameter int FREQ_MAX   = 3903,
  parameter int WK_EXP_MAX = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_vld_i,
  input  logic [CMD_W-1:0] cmd_word_i,
  output logic [12:0]      cfg_o,
  output logic [7:0]       pm_o,
  output logic [11:0]      freq_o,
  output logic [7:0]       rate_o,
  output logic [3:0]       pwr_o,
  output logic [7:0]       lbd_o,
  output logic [7:0]       sleep_o,
  output logic [7:0]       pb_o,
  output logic [12:0]      wk_o,
  output logic [7:0]       pll_o,
  output logic [7:0]       txl_o,
  output logic             sleep_stb_o,
  output logic             tx_stb_o,
  output logic             swrst_stb_o
);
  cmd_e        kind;
  logic [11:0] f_val;
  logic [4:0]  w_exp;
  logic        f_ok, w_ok, is_swrst;

  assign kind     = cmd_vld_i ? classify(cmd_word_i[15:8]) : CMD_NONE;
  assign f_val    = cmd_word_i[11:0];
  assign w_exp    = cmd_word_i[12:8];
  assign f_ok     = (int'(f_val) >= FREQ_MIN) && (int'(f_val) <= FREQ_MAX);
  assign w_ok     = int'(w_exp) <= WK_EXP_MAX;
  assign is_swrst = (kind == CMD_WAKE) && (cmd_word_i == SWRST_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= CFG_DEF;   pm_o    <= PM_DEF;    freq_o <= FREQ_DEF;
      rate_o <= RATE_DEF; pwr_o   <= PWR_DEF;   lbd_o  <= LBD_DEF;
      sleep_o <= SLEEP_DEF; pb_o  <= PB_DEF;    wk_o   <= WK_DEF;
      pll_o <= PLL_DEF;   txl_o   <= TXL_DEF;
    end else if (is_swrst) begin
      cfg_o <= CFG_DEF;   pm_o    <= PM_DEF;    freq_o <= FREQ_DEF;
      rate_o <= RATE_DEF; pwr_o   <= PWR_DEF;   lbd_o  <= LBD_DEF;
      sleep_o <= SLEEP_DEF; pb_o  <= PB_DEF;    wk_o   <= WK_DEF;
      pll_o <= PLL_DEF;   txl_o   <= TXL_DEF;
    end else begin
      unique case (kind)
        CMD_CFG:   cfg_o   <= cmd_word_i[12:0];
        CMD_PM:    pm_o    <= cmd_word_i[7:0];
        CMD_FREQ:  if (f_ok) freq_o <= f_val;
        CMD_RATE:  rate_o  <= cmd_word_i[7:0];
        CMD_PWR:   pwr_o   <= cmd_word_i[11:8];
        CMD_LBD:   lbd_o   <= cmd_word_i[7:0];
        CMD_SLEEP: sleep_o <= cmd_word_i[7:0];
        CMD_PB:    pb_o    <= cmd_word_i[7:0];
        CMD_WAKE:  if (w_ok) wk_o <= cmd_word_i[12:0];
        CMD_PLL:   pll_o   <= cmd_word_i[7:0];
        CMD_TX:    txl_o   <= cmd_word_i[7:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_stb_o <= 1'b0;
      tx_stb_o    <= 1'b0;
      swrst_stb_o <= 1'b0;
    end else begin
      sleep_stb_o <= (kind == CMD_SLEEP);
      tx_stb_o    <= (kind == CMD_TX);
      swrst_stb_o <= is_swrst;
    end
  end

  p_freq_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(freq_o) >= FREQ_MIN) && (int'(freq_o) <= FREQ_MAX));
  p_wk_exp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wk_o[12:8]) <= WK_EXP_MAX);
  p_swrst_defaults_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_stb_o |-> (freq_o == FREQ_DEF) && (wk_o == WK_DEF) && (sleep_o == SLEEP_DEF));
  p_strobe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sleep_stb_o, tx_stb_o, swrst_stb_o}));
  p_strobe_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_stb_o |=> !tx_stb_o);
endmodule

// File: rtl/txcfg_stat.sv
module txcfg_stat #(
  parameter int STAT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_n_i,
  input  logic              sck_fall_i,
  input  logic              arm_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              irq_ni,
  output logic              irq_no
);
  logic              armed_q, active_q;
  logic [STAT_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      sh_q     <= '0;
    end else if (sel_n_i) begin
      armed_q  <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (arm_i) armed_q <= 1'b1;
      if (sck_fall_i && armed_q && !active_q) begin
        sh_q     <= status_i;
        active_q <= 1'b1;
      end else if (sck_fall_i && active_q) begin
        sh_q <= {sh_q[STAT_W-2:0], 1'b0};
      end
    end
  end

  assign irq_no = active_q ? sh_q[STAT_W-1] : irq_ni;

  // R9: pin returns to interrupt duty once the select window closes
  p_stat_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sel_n_i) |-> (irq_no == irq_ni));
endmodule

// File: rtl/txcfg_spi_decoder.sv
module txcfg_spi_decoder
  import txcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STAT_W      = 16,
  parameter int FREQ_MIN    = 96,
  parameter int FREQ_MAX    = 3903,
  parameter int WK_EXP_MAX  = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              sel_ni,
  input  logic              sdi_i,
  input  logic              irq_ni,
  input  logic [STAT_W-1:0] status_i,
  output logic              irq_no,
  output logic [1:0]        band_o,
  output logic [2:0]        clk_sel_o,
  output logic [3:0]        xtal_cap_o,
  output logic              dev_pol_o,
  output logic [2:0]        dev_o,
  output logic [7:0]        pm_en_o,
  output logic [11:0]       freq_o,
  output logic [7:0]        rate_o,
  output logic              pa_ook_o,
  output logic [2:0]        pa_att_o,
  output logic [7:0]        lbd_cfg_o,
  output logic [7:0]        clk_tail_o,
  output logic [7:0]        pb_cfg_o,
  output logic [4:0]        wk_exp_o,
  output logic [7:0]        wk_mant_o,
  output logic [7:0]        pll_cfg_o,
  output logic [7:0]        tx_len_o,
  output logic              sleep_stb_o,
  output logic              tx_stb_o,
  output logic              swrst_stb_o
);
  logic [2:0] raw, syn;
  logic       sck_s, sel_s, sdi_s, sck_d_q, sck_rise, sck_fall;
  logic             cmd_vld, stat_arm;
  logic [CMD_W-1:0] cmd_word;
  logic [12:0]      cfg_q, wk_q;
  logic [3:0]       pwr_q;

  assign raw = {sck_i, sel_ni, sdi_i};

  txcfg_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );
  assign {sck_s, sel_s, sdi_s} = syn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d_q <= 1'b0;
    else         sck_d_q <= sck_s;
  end
  assign sck_rise = sck_s && !sck_d_q;
  assign sck_fall = !sck_s && sck_d_q;

  txcfg_shift u_shift (
    .clk_i, .rst_ni, .sel_n_i(sel_s), .sck_rise_i(sck_rise), .sdi_i(sdi_s),
    .cmd_vld_o(cmd_vld), .cmd_word_o(cmd_word), .stat_arm_o(stat_arm)
  );

  txcfg_regs #(.FREQ_MIN(FREQ_MIN), .FREQ_MAX(FREQ_MAX), .WK_EXP_MAX(WK_EXP_MAX)) u_regs (
    .clk_i, .rst_ni, .cmd_vld_i(cmd_vld), .cmd_word_i(cmd_word),
    .cfg_o(cfg_q), .pm_o(pm_en_o), .freq_o(freq_o), .rate_o(rate_o), .pwr_o(pwr_q),
    .lbd_o(lbd_cfg_o), .sleep_o(clk_tail_o), .pb_o(pb_cfg_o), .wk_o(wk_q),
    .pll_o(pll_cfg_o), .txl_o(tx_len_o), .sleep_stb_o(sleep_stb_o),
    .tx_stb_o(tx_stb_o), .swrst_stb_o(swrst_stb_o)
  );

  txcfg_stat #(.STAT_W(STAT_W)) u_stat (
    .clk_i, .rst_ni, .sel_n_i(sel_s), .sck_fall_i(sck_fall), .arm_i(stat_arm),
    .status_i(status_i), .irq_ni(irq_ni), .irq_no(irq_no)
  );

  assign band_o     = cfg_q[12:11];
  assign clk_sel_o  = cfg_q[10:8];
  assign xtal_cap_o = cfg_q[7:4];
  assign dev_pol_o  = cfg_q[3];
  assign dev_o      = cfg_q[2:0];
  assign pa_ook_o   = pwr_q[3];
  assign pa_att_o   = pwr_q[2:0];
  assign wk_exp_o   = wk_q[12:8];
  assign wk_mant_o  = wk_q[7:0];
endmodule

// File: tb/txcfg_spi_decoder_tb_top.sv
module txcfg_spi_decoder_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sel_n = 1'b1, sdi = 1'b0, irq_n = 1'b1;
  logic [15:0] status = '0;
  logic irq_o;
  logic [1:0] band; logic [2:0] clk_sel; logic [3:0] xcap; logic dpol; logic [2:0] dev;
  logic [7:0] pm, rate, lbd, tail, pb, pll, txl, wmant; logic [11:0] freq;
  logic ook; logic [2:0] att; logic [4:0] wexp;
  logic slp_stb, tx_stb, rst_stb;

  int n_cmp = 0, n_bad = 0, n_slp = 0, n_tx = 0, n_rst = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  txcfg_spi_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sel_ni(sel_n), .sdi_i(sdi),
    .irq_ni(irq_n), .status_i(status), .irq_no(irq_o),
    .band_o(band), .clk_sel_o(clk_sel), .xtal_cap_o(xcap), .dev_pol_o(dpol), .dev_o(dev),
    .pm_en_o(pm), .freq_o(freq), .rate_o(rate), .pa_ook_o(ook), .pa_att_o(att),
    .lbd_cfg_o(lbd), .clk_tail_o(tail), .pb_cfg_o(pb), .wk_exp_o(wexp), .wk_mant_o(wmant),
    .pll_cfg_o(pll), .tx_len_o(txl), .sleep_stb_o(slp_stb), .tx_stb_o(tx_stb),
    .swrst_stb_o(rst_stb)
  );

  always @(posedge clk) begin
    if (slp_stb) n_slp++;
    if (tx_stb)  n_tx++;
    if (rst_stb) n_rst++;
  end

  logic [12:0] e_cfg, e_wk; logic [7:0] e_pm, e_rate, e_lbd, e_slp, e_pb, e_pll, e_txl;
  logic [11:0] e_freq; logic [3:0] e_pwr;

  task automatic set_defaults();
    e_cfg = 13'h0080; e_pm = 8'h00; e_freq = 12'h7D0; e_rate = 8'h00; e_pwr = 4'h0;
    e_lbd = 8'h00; e_slp = 8'h10; e_pb = 8'h00; e_wk = 13'h0000; e_pll = 8'h00; e_txl = 8'h00;
  endtask

  function automatic logic [97:0] got_vec();
    return {band, clk_sel, xcap, dpol, dev, pm, freq, rate, ook, att, lbd, tail, pb,
            wexp, wmant, pll, txl};
  endfunction

  function automatic logic [97:0] exp_vec();
    return {e_cfg, e_pm, e_freq, e_rate, e_pwr, e_lbd, e_slp, e_pb, e_wk, e_pll, e_txl};
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic check_regs(input string req);
    check(req, 128'(got_vec()), 128'(exp_vec()));
  endtask

  task automatic xfer(input logic [31:0] data, input int nbits, output logic [31:0] rd);
    rd = '0;
    sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = data[nbits-1-i];
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
      rd[nbits-1-i] = irq_o;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    sck = 1'b0;
    repeat (HALF) @(negedge clk);
    sel_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send16(input logic [15:0] w);
    logic [31:0] rd;
    xfer({16'h0, w}, 16, rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    set_defaults();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state and R9 idle passthrough
    check_regs("R1 reset defaults");
    check("R1 strobes idle", 128'({slp_stb, tx_stb, rst_stb}), 128'(0));
    irq_n = 1'b0; @(negedge clk);
    check("R9 idle irq low", 128'(irq_o), 128'(0));
    irq_n = 1'b1; @(negedge clk);
    check("R9 idle irq high", 128'(irq_o), 128'(1));

    // R3 config sweep, fields at bits 12:11/10:8/7:4/3/2:0
    for (int i = 0; i < 32; i++) begin
      logic [12:0] pl;
      pl = 13'((i * 1237) ^ (i << 7));
      send16({3'b100, pl});
      e_cfg = pl;
      check_regs("R3 config sweep");
    end

    // R3 and R9: irq passthrough during a normal command
    irq_n = 1'b1;
    xfer({16'h0, 16'hC0A5}, 16, rd); e_pm = 8'hA5;
    check("R9 passthrough high in command", 128'(rd[15:0]), 128'(16'hFFFF));
    check_regs("R3 power enables");
    irq_n = 1'b0;
    xfer({16'h0, 16'hC8C3}, 16, rd); e_rate = 8'hC3;
    check("R9 passthrough low in command", 128'(rd[15:0]), 128'(16'h0000));
    irq_n = 1'b1;
    send16(16'hC2B7); e_lbd = 8'hB7;
    send16(16'hCA5E); e_pb = 8'h5E;
    send16(16'hD23C); e_pll = 8'h3C;
    check_regs("R3 byte-payload commands");

    // R3 power setting, 8-bit frames
    for (int p = 0; p < 16; p++) begin
      xfer({24'h0, 4'b1011, 4'(p)}, 8, rd);
      e_pwr = 4'(p);
      check_regs("R3 power 8-bit command");
    end

    // R4 frequency range
    begin
      int fl[10] = '{0, 95, 96, 97, 2048, 3902, 3903, 3904, 4095, 150};
      foreach (fl[k]) begin
        send16({4'b1010, 12'(fl[k])});
        if (fl[k] >= 96 && fl[k] <= 3903) e_freq = 12'(fl[k]);
        check_regs("R4 frequency range");
      end
    end

    // R5 wake-up exponent sweep, exponent 12:8, mantissa 7:0
    for (int e = 0; e < 32; e++) begin
      logic [7:0] m;
      m = 8'(e * 7 + 1);
      send16({3'b111, 5'(e), m});
      if (e <= 23) e_wk = {5'(e), m};
      check_regs("R5 wake exponent");
    end
    check("R6 no reset from exponent sweep", 128'(n_rst), 128'(0));

    // R7 sleep
    send16(16'hC45A); e_slp = 8'h5A;
    check_regs("R7 sleep tail");
    check("R7 sleep strobe count", 128'(n_slp), 128'(1));

    // R8 transmit
    send16(16'hC605); e_txl = 8'h05;
    check_regs("R8 tx length");
    check("R8 tx strobe count", 128'(n_tx), 128'(1));

    // R2 truncated frames
    xfer({16'h0, 16'hA123} >> 4, 12, rd);
    check_regs("R2 truncated 16-bit discarded");
    xfer({28'h0, 4'b1011}, 4, rd);
    check_regs("R2 truncated 8-bit discarded");
    send16(16'hA123); e_freq = 12'h123;
    check_regs("R2 full frame after truncation");

    // R10 trailing bits and unknown opcodes
    xfer({8'h0, 16'hA100, 8'hB7}, 24, rd); e_freq = 12'h100;
    check_regs("R10 trailing bits ignored");
    send16(16'h1234); send16(16'hD0FF); send16(16'hCE55);
    check_regs("R10 unknown opcodes");
    check("R10 no strobes", 128'({n_slp, n_tx, n_rst}), 128'({32'd1, 32'd1, 32'd0}));

    // R9 status readout
    begin
      logic [15:0] pats[5] = '{16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF, 16'h1234};
      foreach (pats[k]) begin
        status = pats[k];
        irq_n = k[0];
        xfer({8'h0, 24'hCC0000}, 24, rd);
        check("R9 status readout", 128'(rd[15:0]), 128'(pats[k]));
        check_regs("R10 status read leaves registers");
      end
      irq_n = 1'b1;
    end

    // R6 soft reset
    send16(16'hFE01);
    check_regs("R6 FE01 is not reset");
    check("R6 FE01 no strobe", 128'(n_rst), 128'(0));
    send16(16'hFE00);
    set_defaults();
    check_regs("R6 soft reset defaults");
    check("R6 reset strobe count", 128'(n_rst), 128'(1));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule